// File: doc/BRIEF.md
# Passive Serial Configuration Host

This controller sits on the host side of a passive serial configuration link and loads a bitstream into a programmable target. It drives the target's active-low configuration request line. It watches the target's open-drain status line and its configuration-done line. It puts the bitstream on a single data line, one bit for each data clock it generates. Bitstream bytes come from a valid/ready byte stream, and a `last` marker flags the final byte.

After reset the controller waits out the target's power-on interval and then sits idle. A start pulse makes it drive a low pulse on the request line. It then waits for the target to release the status line. It shifts bytes out least-significant bit first until the done line goes high. It then gives a fixed number of extra clocks for the target's start-up, raises its done flag and returns to idle.

A status drop during loading is an error, and so is a stream that ends without the done line going high. In either case the controller stops clocking, raises its error flag and stays there until the user pulses start again.

Top module: `ps_cfg_host`

## Requirements
- R1: While reset is held: `busy_o`=1, `cfg_req_n_o`=1, `dclk_o`=0, `data_o`=0, `done_o`=0, `err_o`=0, `s_ready_o`=0.
- R2: For exactly POR_CYC clock cycles after reset release, `busy_o` stays 1 and `cfg_req_n_o` stays 1. A start pulse in that window is ignored.
- R3: A start pulse in idle or error drives `cfg_req_n_o` low for exactly REQ_LOW_CYC clock cycles, then releases it high.
- R4: `dclk_o` does not rise and `s_ready_o` stays 0 until the status line is high after the request line has risen. `dclk_o` never rises while either line is low.
- R5: The data clock period is CLK_DIV system clocks, low for the first half and high for the second. `data_o` changes only while `dclk_o` is low.
- R6: Bits are sent least-significant first within a byte, and bytes go out in stream order.
- R7: Once the done line is high, exactly INIT_CLKS further rising edges of `dclk_o` follow. Then `done_o`=1 and `busy_o`=0.
- R8: If the status line goes low during loading, `dclk_o` stops at once, `err_o` becomes 1 and `busy_o` becomes 0.
- R9: If the byte marked `last` has been fully sent and the done line is still low, `err_o` becomes 1 with no further clocking.
- R10: `err_o` and `done_o` stay set until a start pulse, which clears both in the same cycle that the request line falls.
- R11: A start pulse while busy is ignored: the request line does not fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart request, sampled when idle or in error |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Controller accepts a byte |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| status_n_i | input | 1 | Target's open-drain status line (low = target in reset) |
| done_i | input | 1 | Target's configuration-done line |
| dclk_o | output | 1 | Data clock to the target |
| data_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | A power-on wait or a configuration attempt is in progress |
| done_o | output | 1 | Last attempt completed |
| err_o | output | 1 | Last attempt failed |

## Verification
A start driven before clock edge k moves the state at edge k. So the request line is low at the following sample, and it is counted low at exactly REQ_LOW_CYC samples taken away from the edge. The power-on interval is counted the same way: `busy_o` falls on the POR_CYC-th sample after reset release. Bits are captured by a target model on each rising edge of `dclk_o`, and rising edges are timestamped in system cycles, so the period check is exact. The error checks wait a few cycles after the status drop or the stream's end, then confirm over a further hundred cycles that no `dclk_o` edge appears and that the flags hold.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_POR,
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_LOAD,
    ST_INIT,
    ST_ERR
  } cfg_state_t;
endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int TW      = 10,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = val_i;
    else if (dec_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TW'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: a loaded count takes effect on the next cycle
  assert_load_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/ps_cfg_clkgen.sv
module ps_cfg_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic dclk_o,
  output logic bit_end_o
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = '0;
    if (run_i && ph_q != PW'(DIV - 1)) ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign dclk_o    = run_i && (ph_q >= PW'(HALF));
  assign bit_end_o = run_i && (ph_q == PW'(DIV - 1));

  // R5: every bit period ends with the data clock back low
  assert_low_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |=> !dclk_o);
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       last_i,
  input  logic       shift_i,
  output logic       have_o,
  output logic       last_o,
  output logic       bit_o
);
  logic [7:0] sr_q, sr_d;
  logic [2:0] idx_q, idx_d;
  logic       have_q, have_d;
  logic       last_q, last_d;

  always_comb begin
    sr_d   = sr_q;
    idx_d  = idx_q;
    have_d = have_q;
    last_d = last_q;
    if (clr_i) begin
      have_d = 1'b0;
      last_d = 1'b0;
    end else if (load_i) begin
      sr_d   = byte_i;
      idx_d  = '0;
      have_d = 1'b1;
      last_d = last_i;
    end else if (shift_i && have_q) begin
      sr_d  = {1'b0, sr_q[7:1]};
      idx_d = idx_q + 1'b1;
      if (idx_q == 3'd7) have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      idx_q  <= idx_d;
      have_q <= have_d;
      last_q <= last_d;
    end
  end

  assign have_o = have_q;
  assign last_o = last_q;
  assign bit_o  = sr_q[0];

  // R6: a new byte is never accepted over one still being sent
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !have_q);
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int POR_CYC     = 625,
  parameter int REQ_LOW_CYC = 250,
  parameter int INIT_CLKS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       cfg_req_n_o,
  input  logic       status_n_i,
  input  logic       done_i,
  output logic       dclk_o,
  output logic       data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int MAX1 = (POR_CYC > REQ_LOW_CYC) ? POR_CYC : REQ_LOW_CYC;
  localparam int MAXV = (MAX1 > INIT_CLKS) ? MAX1 : INIT_CLKS;
  localparam int TW   = $clog2(MAXV + 1);
  localparam logic [TW-1:0] REQ_LD  = TW'(REQ_LOW_CYC - 1);
  localparam logic [TW-1:0] INIT_LD = TW'(INIT_CLKS - 1);

  cfg_state_t st_q, st_d;
  logic done_q, done_d, err_q, err_d;
  logic tmr_load, tmr_dec, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic run, bit_end, have, last_seen, sh_bit, sh_clr, sh_load, restart;

  ps_cfg_timer #(.TW(TW), .RST_VAL(POR_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero));

  ps_cfg_clkgen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .dclk_o(dclk_o), .bit_end_o(bit_end));

  ps_cfg_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .clr_i(sh_clr), .load_i(sh_load),
    .byte_i(s_data_i), .last_i(s_last_i), .shift_i(bit_end && st_q == ST_LOAD),
    .have_o(have), .last_o(last_seen), .bit_o(sh_bit));

  assign restart   = start_i && (st_q == ST_IDLE || st_q == ST_ERR);
  assign s_ready_o = (st_q == ST_LOAD) && !have && !last_seen;
  assign sh_load   = s_ready_o && s_valid_i;
  assign sh_clr    = restart;
  assign run       = ((st_q == ST_LOAD) && have && status_n_i) || (st_q == ST_INIT);

  always_comb begin
    st_d     = st_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = REQ_LD;
    tmr_dec  = (st_q == ST_POR) || (st_q == ST_REQ);
    if (restart) begin
      st_d     = ST_REQ;
      tmr_load = 1'b1;
      done_d   = 1'b0;
      err_d    = 1'b0;
    end else begin
      case (st_q)
        ST_POR:  if (tmr_zero) st_d = ST_IDLE;
        ST_REQ:  if (tmr_zero) st_d = ST_WAIT;
        ST_WAIT: if (status_n_i) st_d = ST_LOAD;
        ST_LOAD: begin
          if (!status_n_i) begin
            st_d  = ST_ERR;
            err_d = 1'b1;
          end else if (done_i && (!have || bit_end)) begin
            st_d     = ST_INIT;
            tmr_load = 1'b1;
            tmr_val  = INIT_LD;
          end else if (!have && last_seen) begin
            st_d  = ST_ERR;
            err_d = 1'b1;
          end
        end
        ST_INIT: if (bit_end) begin
          if (tmr_zero) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POR;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign cfg_req_n_o = (st_q != ST_REQ);
  assign data_o      = (st_q == ST_LOAD) && have && sh_bit;
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_ERR);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R4: the data clock only rises with the target out of reset
  assert_clk_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> (status_n_i && cfg_req_n_o));
  // R5: data line held while the data clock is high
  assert_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));
  // R7: completion is only flagged out of the start-up clocking phase
  assert_done_from_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(st_q) == ST_INIT));
  // R10: the error flag holds until a start pulse
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);
endmodule

// File: tb/test_ps_cfg_host.sv
`timescale 1ns/1ps
module test_ps_cfg_host;
  localparam int DIV = 4, POR = 40, REQ = 20, INIT = 5;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_valid_i = 1'b0, s_last_i = 1'b0, s_ready_o;
  logic cfg_req_n_o, status_n_i, done_i, dclk_o, data_o, busy_o, done_o, err_o;
  logic tgt_stat = 1'b1, tgt_done = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int rx_cnt = 0, need_bits = 0, init_rises = 0, rise_cnt = 0, req_falls = 0;
  int rise_t0 = 0, rise_t1 = 0;
  logic rx_bits [0:63];
  logic [7:0] src [0:7];
  int src_n = 0, src_idx = 0;
  logic hs_pend = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  assign status_n_i = tgt_stat & cfg_req_n_o;
  assign done_i     = tgt_done;

  ps_cfg_host #(.CLK_DIV(DIV), .POR_CYC(POR), .REQ_LOW_CYC(REQ), .INIT_CLKS(INIT)) i_ps_cfg_host (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_data_i(s_data_i),
    .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .cfg_req_n_o(cfg_req_n_o), .status_n_i(status_n_i), .done_i(done_i),
    .dclk_o(dclk_o), .data_o(data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  // target model: captures bits on data clock rises
  always @(posedge dclk_o) begin
    rise_cnt++;
    if (rise_cnt == 1) rise_t0 = cyc;
    if (rise_cnt == 2) rise_t1 = cyc;
    if (tgt_done) init_rises++;
    else if (cfg_req_n_o && status_n_i) begin
      rx_bits[rx_cnt] = data_o;
      rx_cnt++;
      if (rx_cnt == need_bits) tgt_done = 1'b1;
    end
  end
  always @(negedge cfg_req_n_o) begin
    req_falls++;
    rx_cnt = 0; tgt_done = 1'b0; init_rises = 0; rise_cnt = 0;
  end

  // byte source, driven away from the clock edge
  always @(negedge clk) begin
    if (hs_pend) src_idx++;
    s_valid_i = (src_idx < src_n);
    s_data_i  = (src_idx < src_n) ? src[src_idx] : 8'h00;
    s_last_i  = (src_idx == src_n - 1);
    hs_pend   = s_valid_i && s_ready_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic set_src(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3);
    src[0] = b0; src[1] = b1; src[2] = b2; src[3] = b3;
    src_idx = 0; src_n = n;
  endtask

  task automatic check_bits(input int nb, input string req);
    int bad = 0;
    for (int i = 0; i < nb; i++)
      if (rx_bits[i] !== src[i/8][i%8]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset_por;
    int n = 0, req_low = 0;
    @(negedge clk);
    chk(busy_o && cfg_req_n_o && !dclk_o && !data_o && !done_o && !err_o && !s_ready_o,
        "R1", {busy_o, cfg_req_n_o, dclk_o, data_o, done_o, err_o, s_ready_o}, 7'b1100000);
    rst_n = 1'b1;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
      if (!cfg_req_n_o) req_low++;
      start_i = (n == 5);
    end
    chk(n == POR, "R2 por length", n, POR);
    chk(req_low == 0 && req_falls == 0, "R2 start ignored in por", req_falls, 0);
  endtask

  task automatic t_good;
    int n = 0, falls0;
    set_src(3, 8'hA5, 8'h3C, 8'h81, 8'h00);
    need_bits = 24; tgt_stat = 1'b0;
    pulse_start;
    while (!cfg_req_n_o) begin n++; @(negedge clk); end
    chk(n == REQ, "R3 request low width", n, REQ);
    wait_cyc(30);
    chk(rise_cnt == 0 && !s_ready_o, "R4 no clock before status", rise_cnt, 0);
    tgt_stat = 1'b1;
    wait_cyc(20);
    falls0 = req_falls;
    pulse_start;
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(req_falls == falls0, "R11 start ignored while busy", req_falls, falls0);
    chk(rise_t1 - rise_t0 == DIV, "R5 data clock period", rise_t1 - rise_t0, DIV);
    check_bits(24, "R6 lsb-first bit order");
    chk(init_rises == INIT, "R7 start-up clocks", init_rises, INIT);
    chk(done_o && !busy_o && !err_o, "R7 done flag", {done_o, busy_o, err_o}, 3'b100);
    wait_cyc(50);
    chk(done_o && init_rises == INIT, "R10 done held", init_rises, INIT);
  endtask

  task automatic t_drop;
    int n = 0, snap;
    set_src(4, 8'h11, 8'h22, 8'h33, 8'h44);
    need_bits = 32;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!cfg_req_n_o && !done_o, "R10 start clears done", done_o, 0);
    while (rx_cnt < 10 && n < 2000) begin @(negedge clk); n++; end
    tgt_stat = 1'b0;
    wait_cyc(3);
    chk(err_o && !busy_o, "R8 error on status drop", {err_o, busy_o}, 2'b10);
    snap = rise_cnt;
    wait_cyc(100);
    chk(rise_cnt == snap, "R8 clock stopped", rise_cnt, snap);
    chk(err_o && cfg_req_n_o, "R10 error held, no retry", {err_o, cfg_req_n_o}, 2'b11);
    tgt_stat = 1'b1;
    set_src(1, 8'hC6, 8'h00, 8'h00, 8'h00);
    need_bits = 8;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!cfg_req_n_o && !err_o, "R10 restart clears error", err_o, 0);
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o && !err_o, "R3 restart completes", done_o, 1);
    check_bits(8, "R6 restart bits");
  endtask

  task automatic t_exhaust;
    int n = 0, snap;
    set_src(2, 8'h5A, 8'hF0, 8'h00, 8'h00);
    need_bits = 24;
    pulse_start;
    while (!err_o && n < 2000) begin @(negedge clk); n++; end
    chk(err_o && !done_o, "R9 error on stream end", err_o, 1);
    chk(rx_cnt == 16, "R9 all bits sent", rx_cnt, 16);
    snap = rise_cnt;
    wait_cyc(100);
    chk(rise_cnt == snap && err_o, "R9 no clock after error", rise_cnt, snap);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_por;
    wait_cyc(5);
    t_good;
    wait_cyc(10);
    t_drop;
    wait_cyc(10);
    t_exhaust;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule